// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Pin Interrupts

This block gives software control of a bank of general-purpose pins through a 32-bit register port. Each pin has a direction bit and an output latch. Software changes the latch only through two strobe registers. Writing ones to one register raises the selected latch bits, and writing ones to the other lowers them. Pin inputs pass through a two-stage synchronizer. The synchronized value can be read back, and it also feeds the interrupt detectors.

Each pin can raise an interrupt. Per-pin bits select the detection type (level or edge) and the active sense (high or rising versus low or falling). A pin is gated by two separate bits: an enable bit and a mask bit. Edge events are held in a pending register until software clears them by writing ones. A level pin's pending bit tracks its qualified input directly. All gated pending bits combine into one registered interrupt line. A parameter flips the meaning of the direction bit, so that a 1 can mean either "drive" or "listen". Detection on both edges is not built in. Software gets it by flipping a pin's polarity bit after each event. The pin count parameter must be between 1 and 31.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, pin_oe and pin_out are all zero in the normal variant, and irq is low.
- R2: A write to offset 0x0C sets each latch bit written as 1, and a write to offset 0x10 clears each latch bit written as 1. Bits written as 0 keep their value, and both offsets read back the latch, which drives pin_out.
- R3: The direction register at offset 0x00 drives pin_oe unchanged when OE_INV is 0. When OE_INV is 1 it drives pin_oe inverted, so after reset all pins are driven.
- R4: Offset 0x04 returns the pin inputs through two register stages. A change at pin_in is readable after the second rising clock edge and not after the first.
- R5: With type bit (offset 0x18) at 0, an enabled pin latches its pending bit (offset 0x20) on a rising input when its polarity bit (offset 0x1C) is 1, or on a falling input when it is 0. The opposite edge leaves pending unchanged. The pending bit is latched on the third clock edge after the pin change.
- R6: With the type bit at 1, the pending bit of an enabled pin equals 1 exactly while the synchronized input equals its polarity bit. Writes to that pending bit have no effect.
- R7: Writing 1 to an edge pending bit clears it. If a new qualifying edge arrives in the same cycle as the clear, the bit stays set.
- R8: A pin contributes to irq only when both its enable bit (offset 0x14) and its mask bit (offset 0x24) are 1. A masked edge pending bit stays readable. A disabled edge pin latches no event.
- R9: Register bits at or above NPINS read as zero and ignore writes.
- R10: irq is registered. It rises on the clock edge after the one that makes the gated pending condition true, and falls the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write while bus_sel is high |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Pad drive enable, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
The collision of interest is a software clear of an edge pending bit and a fresh qualifying edge on the same pin, landing on the same clock edge. The bench times a falling edge on a pin that is already pending, and places the write-one-to-clear so that the pending register samples both events together. It then expects the bit to read as still set. A second, isolated clear then shows that the clear path itself works.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_IN   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_SET  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_ITYP = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IPOL = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_IPND = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_IMSK = 6'h24;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] now_q,
  output logic [N-1:0] prev_q
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> (now_q == $past(meta_q))); // R4
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] lvl_d,
  input  logic [N-1:0] en,
  input  logic [N-1:0] msk,
  input  logic [N-1:0] typ,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] rise, fall, edge_hit, lvl_hit, pend_q, gated;
  logic         irq_q;

  function automatic logic [N-1:0] pick_edge(input logic [N-1:0] p,
                                             input logic [N-1:0] r,
                                             input logic [N-1:0] f);
    return (p & r) | (~p & f);
  endfunction

  function automatic logic [N-1:0] level_match(input logic [N-1:0] v,
                                               input logic [N-1:0] p);
    return ~(v ^ p);
  endfunction

  always_comb begin
    rise     = lvl & ~lvl_d;
    fall     = ~lvl & lvl_d;
    edge_hit = en & ~typ & pick_edge(pol, rise, fall);
    lvl_hit  = en & typ & level_match(lvl, pol);
    pend     = pend_q | lvl_hit;
    gated    = pend & en & msk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= ~typ & ((pend_q & ~clr) | edge_hit);
      irq_q  <= |gated;
    end
  end

  assign irq = irq_q;

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~edge_hit)) |=> ((pend_q & $past(clr & ~edge_hit)) == '0)); // R7
  AST_LEVEL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (|typ) |=> ((pend_q & $past(typ)) == '0)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(|(pend & en & msk))); // R8
  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (|gated) |=> irq_q); // R10
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter bit OE_INV = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int N = NPINS;

  logic [N-1:0] dir_q, out_q, ien_q, ityp_q, ipol_q, imsk_q;
  logic [N-1:0] in_now, in_prev, pend, pend_clr;
  logic [N-1:0] wbits;
  logic         we, we_dir, we_set, we_clr, we_ien, we_ityp, we_ipol, we_ipnd, we_imsk;

  function automatic logic [N-1:0] latch_next(input logic [N-1:0] cur,
                                              input logic [N-1:0] s,
                                              input logic [N-1:0] c);
    return (cur | s) & ~c;
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [N-1:0] v);
    return DATA_W'(v);
  endfunction

  assign wbits   = bus_wdata[N-1:0];
  assign we      = bus_sel & bus_wr;
  assign we_dir  = we && (bus_addr == OFS_DIR);
  assign we_set  = we && (bus_addr == OFS_SET);
  assign we_clr  = we && (bus_addr == OFS_CLR);
  assign we_ien  = we && (bus_addr == OFS_IEN);
  assign we_ityp = we && (bus_addr == OFS_ITYP);
  assign we_ipol = we && (bus_addr == OFS_IPOL);
  assign we_ipnd = we && (bus_addr == OFS_IPND);
  assign we_imsk = we && (bus_addr == OFS_IMSK);
  assign pend_clr = we_ipnd ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      ityp_q <= '0;
      ipol_q <= '0;
      imsk_q <= '0;
    end else begin
      if (we_dir)  dir_q  <= wbits;
      if (we_set || we_clr)
        out_q <= latch_next(out_q, we_set ? wbits : '0, we_clr ? wbits : '0);
      if (we_ien)  ien_q  <= wbits;
      if (we_ityp) ityp_q <= wbits;
      if (we_ipol) ipol_q <= wbits;
      if (we_imsk) imsk_q <= wbits;
    end
  end

  gpio_sync #(.N(N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (pin_in),
    .now_q (in_now),
    .prev_q(in_prev)
  );

  gpio_irq_detect #(.N(N)) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (in_now),
    .lvl_d(in_prev),
    .en   (ien_q),
    .msk  (imsk_q),
    .typ  (ityp_q),
    .pol  (ipol_q),
    .clr  (pend_clr),
    .pend (pend),
    .irq  (irq)
  );

  generate
    if (OE_INV) begin : g_dir_inv
      assign pin_oe = ~dir_q;
    end else begin : g_dir_norm
      assign pin_oe = dir_q;
    end
  endgenerate

  assign pin_out = out_q;

  always_comb begin
    case (bus_addr)
      OFS_DIR:          bus_rdata = widen(dir_q);
      OFS_IN:           bus_rdata = widen(in_now);
      OFS_SET, OFS_CLR: bus_rdata = widen(out_q);
      OFS_IEN:          bus_rdata = widen(ien_q);
      OFS_ITYP:         bus_rdata = widen(ityp_q);
      OFS_IPOL:         bus_rdata = widen(ipol_q);
      OFS_IPND:         bus_rdata = widen(pend);
      OFS_IMSK:         bus_rdata = widen(imsk_q);
      default:          bus_rdata = '0;
    endcase
  end

  always_comb begin
    AST_UPPER_ZERO: assert ((bus_rdata >> N) == '0); // R9
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    we_set |=> ((out_q & $past(wbits)) == $past(wbits))); // R2
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((out_q & $past(wbits)) == '0)); // R2
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_set || we_clr) |=> $stable(out_q)); // R2
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  import gpio_irq_pkg::*;

  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;
  logic [31:0] inv_rdata;
  logic [NP-1:0] inv_out, inv_oe;
  logic inv_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NP), .OE_INV(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  gpio_irq_ctrl #(.NPINS(NP), .OE_INV(1'b1)) dut_inv (
    .clk(clk), .rst_n(rst_n), .bus_sel(1'b0), .bus_wr(1'b0),
    .bus_addr(6'h00), .bus_wdata(32'h0), .bus_rdata(inv_rdata),
    .pin_in('0), .pin_out(inv_out), .pin_oe(inv_oe), .irq(inv_irq));

  typedef struct packed {
    logic [5:0]  wa;
    logic [31:0] wd;
    logic [5:0]  ra;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Register walk: R2 latch strobes, R9 upper bits, plain config registers
  localparam vec_t VEC [10] = '{
    '{6'h00, 32'h0000_01A5, 6'h00, 32'h0000_00A5, 4'd9},
    '{6'h0C, 32'h0000_000F, 6'h0C, 32'h0000_000F, 4'd2},
    '{6'h0C, 32'h0000_00F0, 6'h10, 32'h0000_00FF, 4'd2},
    '{6'h10, 32'h0000_003C, 6'h0C, 32'h0000_00C3, 4'd2},
    '{6'h10, 32'h0000_0000, 6'h10, 32'h0000_00C3, 4'd2},
    '{6'h0C, 32'hFFFF_FF00, 6'h0C, 32'h0000_00C3, 4'd9},
    '{6'h24, 32'hFFFF_FFFF, 6'h24, 32'h0000_00FF, 4'd9},
    '{6'h18, 32'h0000_000F, 6'h18, 32'h0000_000F, 4'd6},
    '{6'h1C, 32'h0000_0055, 6'h1C, 32'h0000_0055, 4'd5},
    '{6'h14, 32'h0000_0000, 6'h14, 32'h0000_0000, 4'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      peek(6'(i * 4), d);
      chk("R1", d, 32'h0);
    end
    chk("R1", {31'h0, irq}, 32'h0);
    chk("R1", 32'(pin_oe), 32'h0);
    chk("R1", 32'(pin_out), 32'h0);
    // R3 inverted variant drives all pins after reset
    chk("R3", 32'(inv_oe), 32'h0000_00FF);

    // R4 input synchronizer latency
    pin_in = 8'h5A;
    tick(1);
    peek(OFS_IN, d); chk("R4", d, 32'h0);
    tick(1);
    peek(OFS_IN, d); chk("R4", d, 32'h0000_005A);
    pin_in = 8'h00;
    tick(3);

    for (int k = 0; k < 10; k++) begin
      wr(VEC[k].wa, VEC[k].wd);
      peek(VEC[k].ra, d);
      chk($sformatf("R%0d", VEC[k].req), d, VEC[k].exp);
    end
    chk("R3", 32'(pin_oe), 32'h0000_00A5);
    chk("R2", 32'(pin_out), 32'h0000_00C3);
    peek(OFS_IN, d); chk("R9", d & 32'hFFFF_FF00, 32'h0);

    // R5 edge detection: pin0 rising, pin1 falling
    wr(OFS_IMSK, 32'hFF);
    wr(OFS_ITYP, 32'h00);
    wr(OFS_IPOL, 32'h01);
    wr(OFS_IPND, 32'hFF);
    wr(OFS_IEN, 32'h03);
    pin_in[0] = 1'b1;
    tick(3);
    peek(OFS_IPND, d); chk("R5", d, 32'h01);
    chk("R10", {31'h0, irq}, 32'h0);
    tick(1);
    chk("R10", {31'h0, irq}, 32'h1);
    pin_in[1] = 1'b1;
    tick(4);
    peek(OFS_IPND, d); chk("R5", d, 32'h01);
    pin_in[1] = 1'b0;
    tick(3);
    peek(OFS_IPND, d); chk("R5", d, 32'h03);

    // R7 clear one bit
    wr(OFS_IPND, 32'h01);
    peek(OFS_IPND, d); chk("R7", d, 32'h02);
    chk("R8", {31'h0, irq}, 32'h1);

    // R8 mask hides irq but pending stays
    wr(OFS_IMSK, 32'hFD);
    tick(1);
    chk("R8", {31'h0, irq}, 32'h0);
    peek(OFS_IPND, d); chk("R8", d, 32'h02);
    wr(OFS_IPND, 32'h02);
    wr(OFS_IMSK, 32'hFF);

    // R8 disabled pin latches nothing
    wr(OFS_IEN, 32'h02);
    pin_in[0] = 1'b0;
    tick(4);
    pin_in[0] = 1'b1;
    tick(4);
    peek(OFS_IPND, d); chk("R8", d, 32'h0);
    chk("R8", {31'h0, irq}, 32'h0);

    // R7 clear colliding with a new falling edge on pin1
    pin_in[1] = 1'b1;
    tick(4);
    pin_in[1] = 1'b0;
    tick(3);
    peek(OFS_IPND, d); chk("R7", d, 32'h02);
    pin_in[1] = 1'b1;
    tick(4);
    pin_in[1] = 1'b0;
    tick(2);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = OFS_IPND; bus_wdata = 32'h02;
    tick(1);
    bus_sel = 1'b0; bus_wr = 1'b0;
    peek(OFS_IPND, d); chk("R7", d, 32'h02);
    wr(OFS_IPND, 32'h02);
    peek(OFS_IPND, d); chk("R7", d, 32'h0);

    // R6 level mode on pin2
    wr(OFS_IEN, 32'h00);
    wr(OFS_IPND, 32'hFF);
    wr(OFS_ITYP, 32'h04);
    wr(OFS_IPOL, 32'h04);
    wr(OFS_IEN, 32'h04);
    pin_in[2] = 1'b1;
    tick(2);
    peek(OFS_IPND, d); chk("R6", d, 32'h04);
    chk("R10", {31'h0, irq}, 32'h0);
    tick(1);
    chk("R10", {31'h0, irq}, 32'h1);
    wr(OFS_IPND, 32'h04);
    peek(OFS_IPND, d); chk("R6", d, 32'h04);
    pin_in[2] = 1'b0;
    tick(2);
    peek(OFS_IPND, d); chk("R6", d, 32'h0);
    tick(1);
    chk("R10", {31'h0, irq}, 32'h0);
    wr(OFS_IPOL, 32'h00);
    peek(OFS_IPND, d); chk("R6", d, 32'h04);
    wr(OFS_IEN, 32'h00);
    peek(OFS_IPND, d); chk("R6", d, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule